// File: doc/BRIEF.md
# Two-Rate System Clock and Edge Strobe Generator

This block turns a fast master clock (nominally 16 MHz) into the phases of a slower system clock. It also produces a short strobe that follows every edge of that system clock. A configuration input chooses the rate. In fast mode the divide-by-eight counter advances on every master cycle, which gives a 2 MHz system clock. In slow mode the counter advances only on every second master cycle, which gives 1 MHz. A change of rate waits for the counter to wrap, so a phase never comes out shortened.

Phi0 is the counter's top bit. Phi2 is Phi0 re-timed by one master cycle. The strobe comes from a short chain of delay registers behind Phi2: it is Phi2 XOR its delayed copy, registered once more. After each rising and each falling edge of Phi2 it is therefore high for a fixed number of master cycles. A memory controller on a display card can use it as a column-strobe timing signal. The master clock is also passed through unchanged. All phases are made locally and have no input from the outside.

Top module: `sysclk_gen`

## Requirements
- R1: A synchronous reset (rst high at a rising edge of clk) drives phi0, phi2 and cas_strobe low by the end of that edge. They stay low while rst stays high.
- R2: With rate_sel = 1 (fast), phi0 has a period of 8 master cycles with 4 high. Counting edges from the first rising edge after reset is released as edge 1, phi0 is high after edges 4 to 7 and 12 to 15.
- R3: With rate_sel = 0 (slow), phi0 has a period of 16 master cycles with 8 high. It is high after edges 8 to 15 and low after edges 16 to 23.
- R4: phi2 after every edge equals the value phi0 had after the previous edge.
- R5: cas_strobe is high for exactly STROBE_STAGES master cycles (default 3). The pulse starts one cycle after each change of phi2, and the strobe is low at all other times. In fast mode after reset it is high after edges 6 to 8 and 10 to 12.
- R6: The rate applied during reset takes effect at once. A later change of rate_sel takes effect only when the counter wraps from 7 to 0. For example, switching from fast to slow after edge 2 keeps phi0 high after edge 4, then low through edge 15 and high from edge 16.
- R7: mclk_o is the master clock passed through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 1 | 1 = fast (divide by 8), 0 = slow (divide by 16) |
| mclk_o | output | 1 | Master clock pass-through |
| phi0 | output | 1 | System clock phase, counter top bit |
| phi2 | output | 1 | phi0 delayed by one master cycle |
| cas_strobe | output | 1 | Fixed-width pulse after each phi2 edge |

## Verification
- **Divider count or rate latch:** a wrong value here moves the next phi0 edge. The error appears at the ports within one system-clock half period, which is at most 8 master cycles.
- **Delay chain:** a bad stage corrupts the strobe width or its start. This shows up at the first phi2 edge after the fault, one cycle later.
- **Bench coverage:** the bench compares every cycle of the first two fast periods against a table. It then checks the slow phases, a rate change made mid-period, and reset taken in the middle of a pulse, so that an early or late edge is caught at the cycle where it appears.

// File: rtl/sysclk_pkg.sv
`timescale 1ns/1ps
package sysclk_pkg;
  typedef enum logic {
    RATE_SLOW = 1'b0,
    RATE_FAST = 1'b1
  } rate_e;
endpackage

// File: rtl/sysclk_prescale.sv
`timescale 1ns/1ps
// Halves the master clock into a one-cycle enable every second cycle.
module sysclk_prescale (
  input  logic clk,
  input  logic rst,
  output logic half_tick
);
  always_ff @(posedge clk) begin
    if (rst) half_tick <= 1'b0;
    else     half_tick <= ~half_tick;
  end
endmodule

// File: rtl/sysclk_divider.sv
`timescale 1ns/1ps
// Divide-by-2**DIV_BITS counter; rate choice latched only at wrap.
module sysclk_divider import sysclk_pkg::*; #(
  parameter int DIV_BITS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic half_tick,
  input  logic rate_sel,
  output logic phi0
);
  localparam int MSB = DIV_BITS - 1;

  logic [MSB:0] cnt;
  logic         fast_q;
  logic         advance;
  logic         at_top;

  assign advance = fast_q | half_tick;
  assign at_top  = &cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      fast_q <= (rate_e'(rate_sel) == RATE_FAST);
    end else if (advance) begin
      cnt <= cnt + 1'b1;
      if (at_top) fast_q <= (rate_e'(rate_sel) == RATE_FAST);
    end
  end

  assign phi0 = cnt[MSB];
endmodule

// File: rtl/sysclk_strobe.sv
`timescale 1ns/1ps
// Re-times phi0 into phi2 and forms an edge strobe via a delay chain.
module sysclk_strobe #(
  parameter int STAGES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic phi0,
  output logic phi2,
  output logic strobe
);
  logic [STAGES-1:0] dly;

  always_ff @(posedge clk) begin
    if (rst) begin
      phi2   <= 1'b0;
      dly[0] <= 1'b0;
      strobe <= 1'b0;
    end else begin
      phi2   <= phi0;
      dly[0] <= phi2;
      strobe <= phi2 ^ dly[STAGES-1];
    end
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_chain
    always_ff @(posedge clk) begin
      if (rst) dly[i] <= 1'b0;
      else     dly[i] <= dly[i-1];
    end
  end
endmodule

// File: rtl/sysclk_gen.sv
`timescale 1ns/1ps
module sysclk_gen #(
  parameter int DIV_BITS      = 3,
  parameter int STROBE_STAGES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic rate_sel,
  output logic mclk_o,
  output logic phi0,
  output logic phi2,
  output logic cas_strobe
);
  logic half_tick;

  assign mclk_o = clk;

  sysclk_prescale u_pre (
    .clk       (clk),
    .rst       (rst),
    .half_tick (half_tick)
  );

  sysclk_divider #(.DIV_BITS(DIV_BITS)) u_div (
    .clk       (clk),
    .rst       (rst),
    .half_tick (half_tick),
    .rate_sel  (rate_sel),
    .phi0      (phi0)
  );

  sysclk_strobe #(.STAGES(STROBE_STAGES)) u_stb (
    .clk    (clk),
    .rst    (rst),
    .phi0   (phi0),
    .phi2   (phi2),
    .strobe (cas_strobe)
  );
endmodule

// File: rtl/sysclk_gen_chk.sv
`timescale 1ns/1ps
module sysclk_gen_chk (
  input logic clk,
  input logic rst,
  input logic phi0,
  input logic phi2,
  input logic strobe
);
  // R1: outputs low in the cycle after a reset edge
  p_reset_low_r1: assert property (@(posedge clk)
    $past(rst) |-> (!phi0 && !phi2 && !strobe));

  // R4: phi2 is phi0 one master cycle later
  p_phi2_follow_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (phi2 == $past(phi0)));

  // R2: a phi0 high phase lasts more than one cycle
  p_phi0_min_high_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(phi0) |=> phi0);

  // R5: every phi2 edge is followed by a strobe
  p_strobe_after_edge_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(phi2) |=> strobe);

  // R5: a strobe starts only just after a phi2 edge
  p_strobe_cause_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(strobe) |-> ($past(phi2) != $past(phi2, 2)));
endmodule

bind sysclk_gen sysclk_gen_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .phi0   (phi0),
  .phi2   (phi2),
  .strobe (cas_strobe)
);

// File: tb/sim_sysclk_gen.sv
`timescale 1ns/1ps
module sim_sysclk_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rate_sel = 1'b1;
  logic mclk_o, phi0, phi2, cas_strobe;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  sysclk_gen u0 (
    .clk        (clk),
    .rst        (rst),
    .rate_sel   (rate_sel),
    .mclk_o     (mclk_o),
    .phi0       (phi0),
    .phi2       (phi2),
    .cas_strobe (cas_strobe)
  );

  // Fast mode, edges 1..16 after reset: {phi0, phi2, cas_strobe}
  localparam logic [2:0] FAST_TBL [16] = '{
    3'b000, 3'b000, 3'b000, 3'b100, 3'b110, 3'b111, 3'b111, 3'b011,
    3'b000, 3'b001, 3'b001, 3'b101, 3'b110, 3'b111, 3'b111, 3'b011
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic start(input logic r);
    @(negedge clk); rst = 1'b1; rate_sel = r;
    @(negedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic edge_k;
    @(posedge clk); #1;
  endtask

  initial begin
    // R1: state right after reset
    start(1'b1);
    chk("R1 phi0 reset", phi0, 1'b0);
    chk("R1 phi2 reset", phi2, 1'b0);
    chk("R1 strobe reset", cas_strobe, 1'b0);

    // R2, R4, R5: table walk over two fast periods
    for (int k = 1; k <= 16; k++) begin
      edge_k();
      chk($sformatf("R2 phi0 edge %0d", k), phi0, FAST_TBL[k-1][2]);
      chk($sformatf("R4 phi2 edge %0d", k), phi2, FAST_TBL[k-1][1]);
      chk($sformatf("R5 strobe edge %0d", k), cas_strobe, FAST_TBL[k-1][0]);
    end

    // R7: pass-through of master clock
    chk("R7 mclk high", mclk_o, 1'b1);
    @(negedge clk); #1;
    chk("R7 mclk low", mclk_o, 1'b0);

    // R1: reset taken in the middle of a strobe pulse
    start(1'b1);
    for (int k = 1; k <= 6; k++) edge_k();
    chk("R1 pre-reset strobe", cas_strobe, 1'b1);
    @(negedge clk); rst = 1'b1;
    edge_k();
    chk("R1 mid phi0", phi0, 1'b0);
    chk("R1 mid phi2", phi2, 1'b0);
    chk("R1 mid strobe", cas_strobe, 1'b0);

    // R3, R5: slow mode phases
    start(1'b0);
    for (int k = 1; k <= 24; k++) begin
      edge_k();
      if (k == 7)  chk("R3 slow phi0 edge 7", phi0, 1'b0);
      if (k == 8)  chk("R3 slow phi0 edge 8", phi0, 1'b1);
      if (k == 15) chk("R3 slow phi0 edge 15", phi0, 1'b1);
      if (k == 16) chk("R3 slow phi0 edge 16", phi0, 1'b0);
      if (k == 23) chk("R3 slow phi0 edge 23", phi0, 1'b0);
      if (k == 9)  chk("R4 slow phi2 edge 9", phi2, 1'b1);
      if (k == 9)  chk("R5 slow strobe edge 9", cas_strobe, 1'b0);
      if (k == 10) chk("R5 slow strobe edge 10", cas_strobe, 1'b1);
      if (k == 12) chk("R5 slow strobe edge 12", cas_strobe, 1'b1);
      if (k == 13) chk("R5 slow strobe edge 13", cas_strobe, 1'b0);
    end

    // R6: fast to slow after edge 2, applied only at wrap
    start(1'b1);
    for (int k = 1; k <= 16; k++) begin
      edge_k();
      if (k == 2)  begin @(negedge clk); rate_sel = 1'b0; end
      if (k == 4)  chk("R6 phi0 edge 4", phi0, 1'b1);
      if (k == 7)  chk("R6 phi0 edge 7", phi0, 1'b1);
      if (k == 12) chk("R6 phi0 edge 12", phi0, 1'b0);
      if (k == 15) chk("R6 phi0 edge 15", phi0, 1'b0);
      if (k == 16) chk("R6 phi0 edge 16", phi0, 1'b1);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule